// File: doc/BRIEF.md
# Return Address Shift Stack

This block keeps the return addresses of a small processor core while subroutine calls and interrupt service are in progress. When a call or interrupt entry occurs, the core raises a push strobe together with the address to resume at. When it executes a return, it raises a pop strobe and takes the resume address from the top-of-stack output.

There is no pointer and no memory array. The stack is a short chain of registers, and every level moves one place down on a push and one place up on a pop. If more entries are pushed than the chain holds, the oldest entry falls off the bottom and no error is reported. If more entries are popped than were pushed, the deepest level copies itself upward and the returned values are stale. When push and pop arrive in the same cycle, only the top entry is replaced. A synchronous reset clears every level.

Top module: `ret_addr_stack`

## Requirements
- R1: With the default configuration of 3 levels, each 10 bits wide, three pushes followed by three pops return the three addresses in reverse order of pushing.
- R2: A push without a pop writes the push address into level 0 and moves the old level 0 into level 1 and the old level 1 into level 2. The top-of-stack output shows the new address after that clock edge.
- R3: The top-of-stack output is driven combinationally from level 0, so during the cycle in which pop is high it already shows the address being returned. A pop without a push moves level 1 into level 0 and level 2 into level 1.
- R4: A fourth push without an intervening pop discards the oldest stored address with no indication. Three pops that follow return the three newest addresses.
- R5: On a pop, level 2 keeps its value. Pops beyond the number of stored entries therefore keep returning the deepest surviving entry, or zero after reset.
- R6: When push and pop are both high in one cycle, level 0 takes the push address and levels 1 and 2 keep their values.
- R7: A synchronous active-high reset clears all levels to zero, and it takes priority over push and pop in the same cycle.
- R8: In a cycle with neither strobe high, every level keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (return) |
| push_addr_i | input | AW (10) | Return address to store on push |
| top_o | output | AW (10) | Current level 0, the return target |

## Verification
Push and pop are the two functions that can fall in the same cycle, and reset can coincide with either of them. The bench sweeps every sequence of four operations drawn from idle, push, pop and push-with-pop, starting from reset. After each sequence it drains the stack with pops, so every level is checked at the output against a model computed from the requirements. The combined strobe passes only if level 0 changes and the deeper entries that come back on later pops are unchanged. Reset is also asserted while both strobes are high, and it must still leave zero on every level.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_DEPTH_DEF = 3;
    localparam int RAS_AW_DEF    = 10;

    typedef enum logic [1:0] {
        RAS_HOLD = 2'b00,
        RAS_PUSH = 2'b01,
        RAS_POP  = 2'b10,
        RAS_SWAP = 2'b11
    } ras_op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } ras_req_t;

    function automatic ras_op_e ras_decode(input ras_req_t req);
        unique case ({req.pop, req.push})
            2'b01:   return RAS_PUSH;
            2'b10:   return RAS_POP;
            2'b11:   return RAS_SWAP;
            default: return RAS_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output ras_op_e op_o
);
    ras_req_t req;

    always_comb begin
        req.push = push_i;
        req.pop  = pop_i;
        op_o     = ras_decode(req);
    end
endmodule

// File: rtl/ras_level.sv
module ras_level
    import ras_pkg::*;
#(
    parameter int  AW     = RAS_AW_DEF,
    parameter bit  IS_TOP = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  ras_op_e       op,
    input  logic [AW-1:0] new_addr,
    input  logic [AW-1:0] from_above,
    input  logic [AW-1:0] from_below,
    output logic [AW-1:0] q
);
    logic [AW-1:0] d;

    always_comb begin
        unique case (op)
            RAS_PUSH: d = from_above;
            RAS_POP:  d = from_below;
            RAS_SWAP: d = IS_TOP ? new_addr : q;
            default:  d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = RAS_DEPTH_DEF,
    parameter int AW    = RAS_AW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] top_o
);
    localparam int LAST = DEPTH - 1;

    ras_op_e       op;
    logic [AW-1:0] lvl_q  [DEPTH];
    logic [AW-1:0] above  [DEPTH];
    logic [AW-1:0] below  [DEPTH];

    ras_ctrl u_ctrl (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        if (i == 0) begin : g_top_src
            assign above[i] = push_addr_i;
        end else begin : g_mid_src
            assign above[i] = lvl_q[i-1];
        end

        if (i == LAST) begin : g_floor
            assign below[i] = lvl_q[i];
        end else begin : g_link
            assign below[i] = lvl_q[i+1];
        end

        ras_level #(
            .AW     (AW),
            .IS_TOP (i == 0)
        ) u_level (
            .clk        (clk),
            .rst        (rst),
            .op         (op),
            .new_addr   (push_addr_i),
            .from_above (above[i]),
            .from_below (below[i]),
            .q          (lvl_q[i])
        );
    end

    assign top_o = lvl_q[0];
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
    parameter int DEPTH = 3,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          push_i,
    input logic          pop_i,
    input logic [AW-1:0] push_addr_i,
    input logic [AW-1:0] top_o,
    input logic [AW-1:0] lvl_q [DEPTH]
);
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lvl_q[0] == '0 && lvl_q[1] == '0 && lvl_q[DEPTH-1] == '0));

    assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> top_o == $past(push_addr_i));

    assert_push_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> lvl_q[1] == $past(lvl_q[0]));

    assert_pop_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> top_o == $past(lvl_q[1]));

    assert_pop_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1]));

    assert_swap_top_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_i && push_i) |=> (top_o == $past(push_addr_i) && $stable(lvl_q[1])
                               && $stable(lvl_q[DEPTH-1])));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!pop_i && !push_i) |=> ($stable(top_o) && $stable(lvl_q[1])
                                 && $stable(lvl_q[DEPTH-1])));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .top_o       (top_o),
    .lvl_q       (lvl_q)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
    localparam int AW = 10;
    localparam int D  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic [AW-1:0] top_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [AW-1:0] m [D];

    ret_addr_stack #(.DEPTH(D), .AW(AW)) dut (
        .clk (clk), .rst (rst), .push_i (push_i), .pop_i (pop_i),
        .push_addr_i (push_addr_i), .top_o (top_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // model update, derived from R2, R3, R5, R6, R8
    task automatic model_step(input logic p, input logic q, input logic [AW-1:0] a);
        if (p && !q) begin
            for (int i = D-1; i > 0; i--) m[i] = m[i-1];
            m[0] = a;
        end else if (q && !p) begin
            for (int i = 0; i < D-1; i++) m[i] = m[i+1];
        end else if (p && q) begin
            m[0] = a;
        end
    endtask

    task automatic do_reset(input logic p, input logic q);
        @(negedge clk);
        rst = 1'b1; push_i = p; pop_i = q; push_addr_i = 10'h2AA;
        @(negedge clk);
        rst = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        for (int i = 0; i < D; i++) m[i] = '0;
        check(top_o, '0, "R7 reset clears top");
    endtask

    task automatic do_op(input logic p, input logic q, input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        push_i = p; pop_i = q; push_addr_i = a;
        #1;
        if (q && !p) check(top_o, m[0], "R3 same-cycle return target");
        @(posedge clk);
        model_step(p, q, a);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        check(top_o, m[0], tag);
    endtask

    initial begin
        for (int i = 0; i < D; i++) m[i] = '0;
        do_reset(1'b0, 1'b0);

        // R1: LIFO order
        do_op(1, 0, 10'h101, "R2 push a");
        do_op(1, 0, 10'h202, "R2 push b");
        do_op(1, 0, 10'h3FF, "R2 push c");
        do_op(0, 1, '0, "R1 pop returns b");
        check(top_o, 10'h202, "R1 second entry");
        do_op(0, 1, '0, "R1 pop returns a");
        check(top_o, 10'h101, "R1 third entry");

        // R4: overflow drops oldest
        do_reset(1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) do_op(1, 0, AW'(k * 16'h41), "R4 push");
        check(top_o, AW'(4 * 16'h41), "R4 newest on top");
        do_op(0, 1, '0, "R4 pop");
        check(top_o, AW'(3 * 16'h41), "R4 second newest");
        do_op(0, 1, '0, "R4 pop");
        check(top_o, AW'(2 * 16'h41), "R4 third newest");
        // R5: further pops return stale deepest copy
        do_op(0, 1, '0, "R5 pop past floor");
        check(top_o, AW'(2 * 16'h41), "R5 stale deepest");
        do_op(0, 1, '0, "R5 pop again");
        check(top_o, AW'(2 * 16'h41), "R5 stale repeat");

        // R6: swap keeps lower levels
        do_reset(1'b0, 1'b0);
        do_op(1, 0, 10'h011, "R2 push");
        do_op(1, 0, 10'h022, "R2 push");
        do_op(1, 1, 10'h333, "R6 swap top");
        check(top_o, 10'h333, "R6 top replaced");
        do_op(0, 1, '0, "R6 lower level kept");
        check(top_o, 10'h011, "R6 level1 intact");

        // R7: reset wins over strobes
        do_reset(1'b1, 1'b1);
        do_op(0, 1, '0, "R7 level1 zero");
        do_op(0, 1, '0, "R7 level2 zero");
        do_reset(1'b1, 1'b0);
        do_op(0, 0, '0, "R8 idle holds");

        // exhaustive sweep: all length-4 sequences of {hold,push,pop,swap}
        for (int s = 0; s < 256; s++) begin
            do_reset(1'b0, 1'b0);
            for (int k = 0; k < 4; k++) begin
                int opc;
                logic [AW-1:0] a;
                opc = (s >> (2 * k)) & 3;
                a = AW'((s * 4 + k) * 37 + 1);
                case (opc)
                    0: do_op(0, 0, a, "R8 sweep hold");
                    1: do_op(1, 0, a, "R2 sweep push");
                    2: do_op(0, 1, a, "R3 sweep pop");
                    default: do_op(1, 1, a, "R6 sweep swap");
                endcase
            end
            for (int k = 0; k < D; k++) do_op(0, 1, '0, "R1 sweep drain");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule